// File: doc/BRIEF.md
# Prefixed Opcode Byte Stream Decoder

This block sits behind an instruction fetch path and receives opcode bytes one per handshake. It recognises the index prefixes (0xDD selects IX, 0xFD selects IY), the extended-group prefix 0xED and the bit-operation prefix 0xCB. It gathers any displacement byte and any trailing immediate or address bytes. Once the last byte of an instruction has been taken, it presents one decoded record.

The record carries:
- an operation class;
- the two 3-bit register fields of the operative opcode byte;
- the selected index register;
- the raw displacement;
- a 16-bit immediate;
- the number of bytes consumed.

The block does not execute anything. It also does no memory access and keeps no timing model. A downstream stage reads the record through a valid/ready pair. While a record waits to be taken, the byte input is stalled.

Top module: `opstream_decoder`

## Requirements
- R1: After synchronous reset `out_valid` is 0 and `in_ready` is 1. Any partially received instruction and its prefix state are discarded, so the next byte is treated as a first byte.
- R2: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1.
  - The record becomes valid in the cycle after the last byte of an instruction is taken.
  - It stays valid with unchanged fields until a cycle with `out_ready` = 1.
  - `in_ready` is 0 whenever `out_valid` is 1.
- R3: An unprefixed or index-prefixed opcode of the form 01dddsss, other than 0x76, is class 1 (register load).
  - `out_dst` always carries bits 5:3 of the operative opcode byte, and `out_src` always carries bits 2:0.
  - Register codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory through HL or the index register, 7=A.
- R4: Opcode 0x76 is class 2 (halt), with or without an index prefix. It never takes a displacement or an immediate, so both fields are 0.
- R5: `out_idx` is 1 after 0xDD, 2 after 0xFD and 0 when no index prefix is present.
  - When several index prefixes arrive in a row, the last one decides.
  - Every prefix byte is counted in `out_len`.
- R6: Under an index prefix, an opcode that addresses memory through HL takes one displacement byte right after the opcode. These are 01xxx110 or 01110xxx other than 0x76, 10xxx110, and 0x34, 0x35 and 0x36.
  - The displacement is reported unchanged as a two's-complement byte in `out_disp`, and is 0 when absent.
  - For 0x36 the displacement comes before the data byte.
- R7: Immediate operands follow the opcode (and the displacement, if any), low byte first. `out_imm` is 0 when there is none.
  - One byte: 00rrr110, 11xxx110, 0x10/0x18/0x20/0x28/0x30/0x38, 0xD3, 0xDB. The byte lands in bits 7:0 and bits 15:8 are 0.
  - Two bytes: 00rr0001, 001xx010, 11xxx010, 11xxx100, 0xC3, 0xCD.
- R8: After a lone 0xCB prefix, bits 7:6 of the next byte give the class: 00→4 (rotate/shift), 01→5 (bit test), 10→6 (bit clear), 11→7 (bit set). The instruction is two bytes long.
- R9: With an index prefix, 0xCB is followed first by the displacement byte and then by the operation byte. Class and register fields come from that fourth byte.
- R10: After 0xED, the following byte picks the class and the 0xED byte clears any earlier index prefix (`out_idx` = 0).

  | Operation byte | Class | Meaning |
  |---|---|---|
  | 01rr1010 | 8 | 16-bit add with carry |
  | 01rr0010 | 9 | 16-bit subtract with borrow |
  | 0x44 | 10 | negate |
  | 101xx0yy | 11 | block transfer/compare/IO |
  | anything else | 12 | other extended |

  Operation bytes of the form 01rr1011 or 01rr0011 are followed by a two-byte address.
- R11: Unprefixed or index-prefixed opcodes 10xxxxxx and 11xxx110 are class 3 (accumulator arithmetic/logic). All remaining unprefixed opcodes are class 0.
- R12: `out_len` saturates at 2^LEN_W − 1 when an instruction, including its prefixes, is longer than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_class | output | 4 | Operation class code |
| out_dst | output | 3 | Bits 5:3 of the operative opcode |
| out_src | output | 3 | Bits 2:0 of the operative opcode |
| out_idx | output | 2 | 0 none, 1 IX, 2 IY |
| out_disp | output | 8 | Signed displacement byte |
| out_imm | output | 16 | Immediate or address operand |
| out_len | output | LEN_W | Bytes consumed, saturating |

## Verification
Several kinds of stream are driven:
- Plain single-byte opcodes, index-prefixed memory forms and index-prefixed non-memory forms. These separate the displacement rule from the prefix rule.
- Both byte orders around 0xCB (plain, and with displacement before the operation byte). These show whether the operation byte is taken from the right position.
- Chains of mixed 0xDD/0xFD prefixes, and an index prefix followed by 0xED. These show which prefix wins and what the length counts.
- Records held under back-pressure while a byte is offered. These show that nothing is swallowed while the output is full.

A reset in the middle of an instruction shows that no stale prefix survives.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int BYTE_W = 8;
  localparam int IMM_W  = 16;
  localparam int FLD_W  = 3;

  localparam logic [BYTE_W-1:0] PFX_IX  = 8'hDD;
  localparam logic [BYTE_W-1:0] PFX_IY  = 8'hFD;
  localparam logic [BYTE_W-1:0] PFX_EXT = 8'hED;
  localparam logic [BYTE_W-1:0] PFX_BIT = 8'hCB;
  localparam logic [BYTE_W-1:0] OPC_HALT = 8'h76;

  localparam logic [1:0] IDX_NONE = 2'd0;
  localparam logic [1:0] IDX_X    = 2'd1;
  localparam logic [1:0] IDX_Y    = 2'd2;

  typedef enum logic [3:0] {
    CLS_OTHER    = 4'd0,
    CLS_LOAD8    = 4'd1,
    CLS_HALT     = 4'd2,
    CLS_ALU8     = 4'd3,
    CLS_ROTSHIFT = 4'd4,
    CLS_BITTEST  = 4'd5,
    CLS_BITCLR   = 4'd6,
    CLS_BITSET   = 4'd7,
    CLS_ADC16    = 4'd8,
    CLS_SBC16    = 4'd9,
    CLS_NEG      = 4'd10,
    CLS_BLOCK    = 4'd11,
    CLS_EXT      = 4'd12
  } op_class_e;

  typedef enum logic [1:0] {
    GRP_BASE  = 2'd0,
    GRP_EXT   = 2'd1,
    GRP_BITOP = 2'd2
  } grp_e;
endpackage

// File: rtl/osd_opinfo.sv
module osd_opinfo
  import osd_pkg::*;
(
  input  grp_e              grp,
  input  logic              indexed,
  input  logic [BYTE_W-1:0] opc,
  output op_class_e         cls,
  output logic              needs_disp,
  output logic [1:0]        imm_cnt
);
  logic [1:0] fx;
  logic [2:0] fy;
  logic [2:0] fz;

  assign fx = opc[7:6];
  assign fy = opc[5:3];
  assign fz = opc[2:0];

  always_comb begin
    cls        = CLS_OTHER;
    needs_disp = 1'b0;
    imm_cnt    = 2'd0;
    case (grp)
      GRP_BITOP: begin
        case (fx)
          2'd0:    cls = CLS_ROTSHIFT;
          2'd1:    cls = CLS_BITTEST;
          2'd2:    cls = CLS_BITCLR;
          default: cls = CLS_BITSET;
        endcase
      end
      GRP_EXT: begin
        if (fx == 2'd1 && fz == 3'd2)
          cls = opc[3] ? CLS_ADC16 : CLS_SBC16;
        else if (opc == 8'h44)
          cls = CLS_NEG;
        else if (fx == 2'd2 && fy[2] && !fz[2])
          cls = CLS_BLOCK;
        else
          cls = CLS_EXT;
        if (fx == 2'd1 && fz == 3'd3)
          imm_cnt = 2'd2;
      end
      default: begin
        case (fx)
          2'd1: begin
            cls = (opc == OPC_HALT) ? CLS_HALT : CLS_LOAD8;
            needs_disp = indexed && (opc != OPC_HALT) && (fy == 3'd6 || fz == 3'd6);
          end
          2'd2: begin
            cls = CLS_ALU8;
            needs_disp = indexed && (fz == 3'd6);
          end
          2'd3: begin
            if (fz == 3'd6) begin
              cls     = CLS_ALU8;
              imm_cnt = 2'd1;
            end else if (fz == 3'd2 || fz == 3'd4 || opc == 8'hC3 || opc == 8'hCD)
              imm_cnt = 2'd2;
            else if (opc == 8'hD3 || opc == 8'hDB)
              imm_cnt = 2'd1;
          end
          default: begin
            needs_disp = indexed && (opc == 8'h34 || opc == 8'h35 || opc == 8'h36);
            if (fz == 3'd6 || (fz == 3'd0 && fy >= 3'd2))
              imm_cnt = 2'd1;
            else if ((fz == 3'd1 && !opc[3]) || (fz == 3'd2 && fy[2]))
              imm_cnt = 2'd2;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/osd_collect.sv
module osd_collect
  import osd_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output grp_e              cur_grp,
  output logic              cur_indexed,
  input  op_class_e         i_cls,
  input  logic              i_disp,
  input  logic [1:0]        i_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_class,
  output logic [FLD_W-1:0]  out_dst,
  output logic [FLD_W-1:0]  out_src,
  output logic [1:0]        out_idx,
  output logic [BYTE_W-1:0] out_disp,
  output logic [IMM_W-1:0]  out_imm,
  output logic [LEN_W-1:0]  out_len
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  typedef enum logic [2:0] {
    ST_HEAD, ST_EXT_OP, ST_BIT_OP, ST_XB_DISP, ST_XB_OP, ST_DISP, ST_IMM_LO, ST_IMM_HI
  } st_e;

  st_e               st, st_n;
  logic [1:0]        idx_r, idx_n;
  logic [LEN_W-1:0]  len_r, len_n;
  logic [BYTE_W-1:0] opc_r, opc_n, disp_r, disp_n;
  logic [IMM_W-1:0]  imm_r, imm_n;
  op_class_e         cls_r, cls_n;
  logic [1:0]        icnt_r, icnt_n;
  logic              take, done;

  assign in_ready    = !out_valid;
  assign take        = in_valid && in_ready;
  assign cur_indexed = (idx_r != IDX_NONE);
  assign len_n       = (len_r == LEN_MAX) ? len_r : len_r + LEN_ONE;

  always_comb begin
    case (st)
      ST_EXT_OP:          cur_grp = GRP_EXT;
      ST_BIT_OP, ST_XB_OP: cur_grp = GRP_BITOP;
      default:            cur_grp = GRP_BASE;
    endcase
  end

  always_comb begin
    st_n = st; idx_n = idx_r; opc_n = opc_r; disp_n = disp_r;
    imm_n = imm_r; cls_n = cls_r; icnt_n = icnt_r; done = 1'b0;
    if (take) begin
      case (st)
        ST_HEAD: begin
          if (in_byte == PFX_IX)       idx_n = IDX_X;
          else if (in_byte == PFX_IY)  idx_n = IDX_Y;
          else if (in_byte == PFX_EXT) begin idx_n = IDX_NONE; st_n = ST_EXT_OP; end
          else if (in_byte == PFX_BIT) st_n = cur_indexed ? ST_XB_DISP : ST_BIT_OP;
          else begin
            opc_n = in_byte; cls_n = i_cls; icnt_n = i_imm;
            if (i_disp)              st_n = ST_DISP;
            else if (i_imm != 2'd0)  st_n = ST_IMM_LO;
            else                     done = 1'b1;
          end
        end
        ST_EXT_OP: begin
          opc_n = in_byte; cls_n = i_cls; icnt_n = i_imm;
          if (i_imm != 2'd0) st_n = ST_IMM_LO;
          else               done = 1'b1;
        end
        ST_BIT_OP, ST_XB_OP: begin
          opc_n = in_byte; cls_n = i_cls; done = 1'b1;
        end
        ST_XB_DISP: begin
          disp_n = in_byte; st_n = ST_XB_OP;
        end
        ST_DISP: begin
          disp_n = in_byte;
          if (icnt_r != 2'd0) st_n = ST_IMM_LO;
          else                done = 1'b1;
        end
        ST_IMM_LO: begin
          imm_n = {8'h00, in_byte};
          if (icnt_r == 2'd2) st_n = ST_IMM_HI;
          else                done = 1'b1;
        end
        default: begin
          imm_n = {in_byte, imm_r[7:0]}; done = 1'b1;
        end
      endcase
      if (done) st_n = ST_HEAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_HEAD; idx_r <= IDX_NONE; len_r <= '0; opc_r <= '0; disp_r <= '0;
      imm_r <= '0; cls_r <= CLS_OTHER; icnt_r <= 2'd0; out_valid <= 1'b0;
      out_class <= '0; out_dst <= '0; out_src <= '0; out_idx <= '0;
      out_disp <= '0; out_imm <= '0; out_len <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        st <= st_n;
        if (done) begin
          out_valid <= 1'b1;
          out_class <= cls_n;
          out_dst   <= opc_n[5:3];
          out_src   <= opc_n[2:0];
          out_idx   <= idx_n;
          out_disp  <= disp_n;
          out_imm   <= imm_n;
          out_len   <= len_n;
          idx_r <= IDX_NONE; len_r <= '0; disp_r <= '0; imm_r <= '0;
          icnt_r <= 2'd0; opc_r <= '0; cls_r <= CLS_OTHER;
        end else begin
          idx_r <= idx_n; len_r <= len_n; opc_r <= opc_n; disp_r <= disp_n;
          imm_r <= imm_n; cls_r <= cls_n; icnt_r <= icnt_n;
        end
      end
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R1
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R2
  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_class, out_dst, out_src,
                                   out_idx, out_disp, out_imm, out_len}))); // R2
  AST_HALT_BARE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 4'(CLS_HALT)) |-> (out_imm == '0 && out_disp == '0)); // R4
  AST_IDX_LEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx != IDX_NONE) |-> (out_len >= LEN_W'(2))); // R5
  AST_IDX_CODE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_idx != 2'd3)); // R5
  AST_DISP_ONLY_INDEXED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx == IDX_NONE) |-> (out_disp == '0)); // R6
  AST_BITOP_NO_IMM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class >= 4'(CLS_ROTSHIFT) && out_class <= 4'(CLS_BITSET))
      |-> (out_imm == '0)); // R8
endmodule

// File: rtl/opstream_decoder.sv
module opstream_decoder
  import osd_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_class,
  output logic [2:0]       out_dst,
  output logic [2:0]       out_src,
  output logic [1:0]       out_idx,
  output logic [7:0]       out_disp,
  output logic [15:0]      out_imm,
  output logic [LEN_W-1:0] out_len
);
  grp_e      cur_grp;
  logic      cur_indexed;
  op_class_e i_cls;
  logic      i_disp;
  logic [1:0] i_imm;

  osd_opinfo u_info (
    .grp        (cur_grp),
    .indexed    (cur_indexed),
    .opc        (in_byte),
    .cls        (i_cls),
    .needs_disp (i_disp),
    .imm_cnt    (i_imm)
  );

  osd_collect #(.LEN_W(LEN_W)) u_collect (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .in_ready    (in_ready),
    .cur_grp     (cur_grp),
    .cur_indexed (cur_indexed),
    .i_cls       (i_cls),
    .i_disp      (i_disp),
    .i_imm       (i_imm),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_class   (out_class),
    .out_dst     (out_dst),
    .out_src     (out_src),
    .out_idx     (out_idx),
    .out_disp    (out_disp),
    .out_imm     (out_imm),
    .out_len     (out_len)
  );
endmodule

// File: tb/test_opstream_decoder.sv
module test_opstream_decoder;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid;
  logic [3:0] out_class;
  logic [2:0] out_dst, out_src;
  logic [1:0] out_idx;
  logic [7:0] out_disp;
  logic [15:0] out_imm;
  logic [3:0] out_len;

  int total = 0, bad = 0;
  bit pend = 0;
  int e_cls, e_dst, e_src, e_idx, e_disp, e_imm, e_len;
  string e_req = "R2";

  opstream_decoder i_opstream_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class), .out_dst(out_dst),
    .out_src(out_src), .out_idx(out_idx), .out_disp(out_disp), .out_imm(out_imm),
    .out_len(out_len)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit mem_form(input logic [7:0] op);
    if (op == 8'h76) return 0;
    if (op inside {[8'h40:8'h7F]}) return (op[2:0] == 3'd6) || (op[5:3] == 3'd6);
    if (op inside {[8'h80:8'hBF]}) return op[2:0] == 3'd6;
    return op inside {8'h34, 8'h35, 8'h36};
  endfunction

  // Reference model: derives the record from the complete byte list
  task automatic ref_model(input bq_t q);
    int i = 0;
    int ix = 0;
    int rest;
    logic [7:0] op;
    e_disp = 0; e_imm = 0;
    while (q[i] == 8'hDD || q[i] == 8'hFD) begin
      ix = (q[i] == 8'hDD) ? 1 : 2;
      i++;
    end
    if (q[i] == 8'hED) begin
      ix = 0; op = q[i+1];
      case (op) inside
        8'h42, 8'h52, 8'h62, 8'h72: e_cls = 9;
        8'h4A, 8'h5A, 8'h6A, 8'h7A: e_cls = 8;
        8'h44: e_cls = 10;
        [8'hA0:8'hA3], [8'hA8:8'hAB], [8'hB0:8'hB3], [8'hB8:8'hBB]: e_cls = 11;
        default: e_cls = 12;
      endcase
      if (q.size() > i + 2) e_imm = int'(q[i+2]) | (int'(q[i+3]) << 8);
    end else if (q[i] == 8'hCB) begin
      if (ix != 0) begin e_disp = q[i+1]; op = q[i+2]; end
      else op = q[i+1];
      e_cls = 4 + int'(op[7:6]);
    end else begin
      op = q[i];
      if (op == 8'h76) e_cls = 2;
      else if (op inside {[8'h40:8'h7F]}) e_cls = 1;
      else if (op inside {[8'h80:8'hBF]}) e_cls = 3;
      else if (op >= 8'hC0 && op[2:0] == 3'd6) e_cls = 3;
      else e_cls = 0;
      rest = i + 1;
      if (ix != 0 && mem_form(op)) begin e_disp = q[rest]; rest++; end
      if (q.size() > rest) e_imm = q[rest];
      if (q.size() > rest + 1) e_imm = e_imm | (int'(q[rest+1]) << 8);
    end
    e_idx = ix; e_dst = op[5:3]; e_src = op[2:0];
    e_len = (q.size() > 15) ? 15 : q.size();
  endtask

  // One clock: sample before the edge, update model, compare after the edge
  task automatic step(input bit is_last, output bit acc);
    bit fire;
    acc  = in_valid && in_ready;
    fire = out_valid && out_ready;
    @(posedge clk);
    @(negedge clk);
    if (fire) pend = 0;
    if (acc && is_last) pend = 1;
    if (rst) pend = 0;
    chk(out_valid == pend, "R2", "out_valid", out_valid, pend);
    chk(in_ready == !pend, "R2", "in_ready", in_ready, !pend);
    if (pend && out_valid) begin
      chk(out_class == e_cls, e_req, "class", out_class, e_cls);
      chk(out_dst == e_dst, e_req, "dst", out_dst, e_dst);
      chk(out_src == e_src, e_req, "src", out_src, e_src);
      chk(out_idx == e_idx, e_req, "idx", out_idx, e_idx);
      chk(out_disp == e_disp, e_req, "disp", out_disp, e_disp);
      chk(out_imm == e_imm, e_req, "imm", out_imm, e_imm);
      chk(out_len == e_len, e_req, "len", out_len, e_len);
    end
  endtask

  task automatic send(input bq_t q, input int hold, input bit poke, input string req);
    bit a;
    int left = hold;
    ref_model(q);
    e_req = req;
    foreach (q[k]) begin
      in_valid = 1'b1; in_byte = q[k];
      a = 0;
      while (!a) step(k == q.size() - 1, a);
    end
    in_valid = 1'b0;
    while (pend) begin
      out_ready = (left == 0);
      in_valid  = poke && (left > 0);
      in_byte   = 8'h00;
      step(0, a);
      if (left > 0) left--;
    end
    in_valid = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bq_t q;
    bit a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    q = '{8'h7E};                   send(q, 0, 0, "R3");
    q = '{8'h47};                   send(q, 0, 0, "R3");
    q = '{8'hDD, 8'h7E, 8'h05};     send(q, 0, 0, "R6");
    q = '{8'hFD, 8'h77, 8'hFE};     send(q, 0, 0, "R6");
    q = '{8'h76};                   send(q, 0, 0, "R4");
    q = '{8'hDD, 8'h76};            send(q, 0, 0, "R4");
    q = '{8'hDD, 8'h36, 8'hF0, 8'h5A}; send(q, 0, 0, "R6");
    q = '{8'hDD, 8'h34, 8'h07};     send(q, 0, 0, "R6");
    q = '{8'h21, 8'h34, 8'h12};     send(q, 0, 0, "R7");
    q = '{8'h3A, 8'h00, 8'h80};     send(q, 3, 1, "R7");
    q = '{8'h18, 8'hFE};            send(q, 0, 0, "R7");
    q = '{8'hDD, 8'h21, 8'h00, 8'h40}; send(q, 0, 0, "R7");
    q = '{8'hCD, 8'h11, 8'h22};     send(q, 2, 0, "R7");
    q = '{8'hC6, 8'h7F};            send(q, 0, 0, "R11");
    q = '{8'h80};                   send(q, 0, 0, "R11");
    q = '{8'hDD, 8'h86, 8'hFC};     send(q, 0, 0, "R11");
    q = '{8'hC9};                   send(q, 0, 0, "R11");
    q = '{8'hCB, 8'h47};            send(q, 0, 0, "R8");
    q = '{8'hCB, 8'h9E};            send(q, 0, 0, "R8");
    q = '{8'hCB, 8'hC1};            send(q, 4, 1, "R8");
    q = '{8'hCB, 8'h21};            send(q, 0, 0, "R8");
    q = '{8'hDD, 8'hCB, 8'h10, 8'h06}; send(q, 0, 0, "R9");
    q = '{8'hFD, 8'hCB, 8'h80, 8'hFE}; send(q, 0, 0, "R9");
    q = '{8'hED, 8'h4A};            send(q, 0, 0, "R10");
    q = '{8'hED, 8'h52};            send(q, 0, 0, "R10");
    q = '{8'hED, 8'h44};            send(q, 0, 0, "R10");
    q = '{8'hED, 8'hB0};            send(q, 0, 0, "R10");
    q = '{8'hED, 8'hA9};            send(q, 0, 0, "R10");
    q = '{8'hED, 8'h4B, 8'h11, 8'h22}; send(q, 0, 0, "R10");
    q = '{8'hED, 8'h56};            send(q, 0, 0, "R10");
    q = '{8'hDD, 8'hED, 8'h44};     send(q, 0, 0, "R10");
    q = '{8'hDD, 8'hFD, 8'hDD, 8'h66, 8'h03}; send(q, 0, 0, "R5");
    q = '{8'hFD, 8'hDD, 8'hFD, 8'h41}; send(q, 0, 0, "R5");

    q.delete();
    for (int n = 0; n < 16; n++) q.push_back(8'hDD);
    q.push_back(8'h00);
    send(q, 0, 0, "R12");

    // reset in the middle of an indexed immediate load
    in_valid = 1'b1; in_byte = 8'hDD; a = 0;
    while (!a) step(0, a);
    in_byte = 8'h21; a = 0;
    while (!a) step(0, a);
    in_valid = 1'b0; rst = 1'b1;
    step(0, a); step(0, a);
    rst = 1'b0;
    q = '{8'h7E};                   send(q, 0, 0, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule